// File: doc/BRIEF.md
# Flash Command Interface Decoder

This block sits between the bus-side write port of a NOR-style flash controller model and the operation sequencer that performs erases, programming and lock-bit changes. Each write cycle presents an address, a 16-bit data word and a one-cycle write strobe. The decoder reads the command code from the low byte of the data word. It keeps track of which kind of data reads should return: the memory array, the identifier space or the status register. It also follows two-cycle command sequences: a setup cycle followed by a confirm cycle or a data cycle.

When a sequence completes, the decoder raises a one-cycle start pulse with an operation kind and passes on the address and data of the closing cycle. A malformed sequence raises a one-cycle error pulse instead. Single-cycle commands ask the sequencer to suspend or resume its work, or to clear the error flags of the status register. While the sequencer reports busy and is not suspended, commands that would leave status reads are held off. The supply sensing, the array and the pin-level bus timing belong to other blocks.

All outputs are registered. They change on the first rising clock edge at which the strobe is sampled high, and pulses last exactly one cycle.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset is released, read mode is array (code 0), no start, error, clear, suspend or resume pulse is present, and no setup cycle is pending, so a lone D0h write that follows starts nothing.
- R2: Single-cycle writes select the read mode on the next cycle: FFh gives array (0), 70h gives status (1) and 90h gives identifier (2).
- R3: A 50h write raises clear_flags for one cycle when the sequencer is not busy and leaves the read mode unchanged. While the sequencer is busy, a 50h write has no effect.
- R4: 20h followed by D0h raises op_start for one cycle with op_kind 1 (erase), with op_addr holding the address of the confirm cycle.
- R5: 20h followed by any code other than D0h raises seq_error (erase and program error together) for one cycle, starts nothing, and clears the pending setup.
- R6: A setup of 40h or 10h followed by any data word raises op_start with op_kind 2 (program), with op_addr and op_data holding the second cycle's address and full 16-bit data, even when that data equals a command code.
- R7: After 60h, a second cycle of 01h gives op_kind 3 (set block lock), F1h gives op_kind 4 (set permanent lock), and D0h gives op_kind 5 (clear all block locks). Any other second code raises seq_error.
- R8: B0h raises suspend_req when the sequencer is busy and not suspended. A single D0h raises resume_req when it is suspended. Either one selects status read mode.
- R9: While busy and not suspended, FFh and 90h leave the read mode unchanged. Once suspended, FFh selects array mode again.
- R10: Every setup cycle, and every completed or malformed two-cycle sequence, selects status read mode.
- R11: Reserved codes, and B0h or a lone D0h when they do not apply, change neither the read mode nor any pulse output.
- R12: Only data bits 7:0 are decoded as the command. Bits 15:8 of a command cycle have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one cycle per bus write |
| wr_addr | input | AW (20) | Latched write address |
| wr_data | input | DW (16) | Latched write data; bits 7:0 are the command |
| seq_busy | input | 1 | Sequencer is running an operation |
| seq_suspended | input | 1 | Sequencer operation is suspended |
| read_mode | output | 2 | 0 array, 1 status, 2 identifier |
| op_start | output | 1 | One-cycle operation start pulse |
| op_kind | output | 3 | 1 erase, 2 program, 3 lock set, 4 permanent lock, 5 lock clear |
| op_addr | output | AW (20) | Address of the closing cycle |
| op_data | output | DW (16) | Data of the closing cycle |
| seq_error | output | 1 | One-cycle pulse for an invalid sequence |
| clear_flags | output | 1 | One-cycle request to clear status error flags |
| suspend_req | output | 1 | One-cycle suspend request |
| resume_req | output | 1 | One-cycle resume request |

## Verification
Each command sequence is driven from a known read mode, and the pulse is checked in the cycle it appears and in the cycle after. This tells a registered one-cycle pulse apart from one that is held or late. Second cycles are varied across the valid confirm, the alternate lock codes and foreign codes, which separates the correct operation kind from an error and from a setup that stays pending. Program data equal to FFh shows that a data cycle is not decoded as a command. Each busy and suspended combination is paired with the commands that depend on it, which exposes gating that is missing or applied too broadly.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

   localparam int CMD_W = 8;

   localparam logic [CMD_W-1:0] C_RD_ARRAY  = 8'hFF;
   localparam logic [CMD_W-1:0] C_RD_STATUS = 8'h70;
   localparam logic [CMD_W-1:0] C_RD_IDENT  = 8'h90;
   localparam logic [CMD_W-1:0] C_CLR_SR    = 8'h50;
   localparam logic [CMD_W-1:0] C_ERASE     = 8'h20;
   localparam logic [CMD_W-1:0] C_PROG      = 8'h40;
   localparam logic [CMD_W-1:0] C_PROG_ALT  = 8'h10;
   localparam logic [CMD_W-1:0] C_LOCK_PFX  = 8'h60;
   localparam logic [CMD_W-1:0] C_SUSPEND   = 8'hB0;
   localparam logic [CMD_W-1:0] C_CONFIRM   = 8'hD0;
   localparam logic [CMD_W-1:0] C_LOCK_ONE  = 8'h01;
   localparam logic [CMD_W-1:0] C_LOCK_PERM = 8'hF1;

   typedef enum logic [1:0] {
      RM_ARRAY  = 2'd0,
      RM_STATUS = 2'd1,
      RM_IDENT  = 2'd2
   } rmode_e;

   typedef enum logic [2:0] {
      OK_NONE  = 3'd0,
      OK_ERASE = 3'd1,
      OK_PROG  = 3'd2,
      OK_LSET  = 3'd3,
      OK_PLOCK = 3'd4,
      OK_LCLR  = 3'd5
   } op_kind_e;

   typedef enum logic [1:0] {
      PD_NONE  = 2'd0,
      PD_ERASE = 2'd1,
      PD_PROG  = 2'd2,
      PD_LOCK  = 2'd3
   } pend_e;

   typedef enum logic [3:0] {
      CL_RESERVED,
      CL_RD_ARRAY,
      CL_RD_STATUS,
      CL_RD_IDENT,
      CL_CLR_SR,
      CL_ERASE_SETUP,
      CL_PROG_SETUP,
      CL_LOCK_SETUP,
      CL_SUSPEND,
      CL_CONFIRM,
      CL_LOCK_ONE,
      CL_LOCK_PERM
   } cmd_class_e;

endpackage

// File: rtl/flash_cmd_classify.sv
module flash_cmd_classify
   import flash_cmd_pkg::*;
#(
   parameter int CODE_W      = 8,
   parameter bit ALT_PROG_EN = 1'b1
) (
   input  logic [CODE_W-1:0] code,
   output cmd_class_e        cls
);

   initial begin
      if (CODE_W != CMD_W) $error("flash_cmd_classify: CODE_W must equal CMD_W");
   end

   cmd_class_e base_cls;

   always_comb begin
      unique case (code)
         C_RD_ARRAY:  base_cls = CL_RD_ARRAY;
         C_RD_STATUS: base_cls = CL_RD_STATUS;
         C_RD_IDENT:  base_cls = CL_RD_IDENT;
         C_CLR_SR:    base_cls = CL_CLR_SR;
         C_ERASE:     base_cls = CL_ERASE_SETUP;
         C_PROG:      base_cls = CL_PROG_SETUP;
         C_LOCK_PFX:  base_cls = CL_LOCK_SETUP;
         C_SUSPEND:   base_cls = CL_SUSPEND;
         C_CONFIRM:   base_cls = CL_CONFIRM;
         C_LOCK_ONE:  base_cls = CL_LOCK_ONE;
         C_LOCK_PERM: base_cls = CL_LOCK_PERM;
         default:     base_cls = CL_RESERVED;
      endcase
   end

   generate
      if (ALT_PROG_EN) begin : g_alt_prog
         assign cls = (code == C_PROG_ALT) ? CL_PROG_SETUP : base_cls;
      end else begin : g_no_alt_prog
         assign cls = base_cls;
      end
   endgenerate

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
   import flash_cmd_pkg::*;
#(
   parameter bit HOLD_IDENT = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       strobe,
   input  cmd_class_e cls,
   input  logic       busy,
   input  logic       suspended,
   output logic       mode_we,
   output rmode_e     mode_nxt,
   output logic       op_fire,
   output op_kind_e   kind_nxt,
   output logic       err_fire,
   output logic       clr_fire,
   output logic       susp_fire,
   output logic       res_fire
);

   pend_e pend_q, pend_d;
   logic  hold;

   assign hold = busy && !suspended;

   always_ff @(posedge clk) begin
      if (!rst_n) pend_q <= PD_NONE;
      else        pend_q <= pend_d;
   end

   always_comb begin
      pend_d    = pend_q;
      mode_we   = 1'b0;
      mode_nxt  = RM_STATUS;
      op_fire   = 1'b0;
      kind_nxt  = OK_NONE;
      err_fire  = 1'b0;
      clr_fire  = 1'b0;
      susp_fire = 1'b0;
      res_fire  = 1'b0;
      if (strobe) begin
         unique case (pend_q)
            PD_ERASE: begin
               pend_d  = PD_NONE;
               mode_we = 1'b1;
               if (cls == CL_CONFIRM) begin
                  op_fire  = 1'b1;
                  kind_nxt = OK_ERASE;
               end else begin
                  err_fire = 1'b1;
               end
            end
            PD_PROG: begin
               pend_d   = PD_NONE;
               mode_we  = 1'b1;
               op_fire  = 1'b1;
               kind_nxt = OK_PROG;
            end
            PD_LOCK: begin
               pend_d  = PD_NONE;
               mode_we = 1'b1;
               unique case (cls)
                  CL_LOCK_ONE:  begin op_fire = 1'b1; kind_nxt = OK_LSET;  end
                  CL_LOCK_PERM: begin op_fire = 1'b1; kind_nxt = OK_PLOCK; end
                  CL_CONFIRM:   begin op_fire = 1'b1; kind_nxt = OK_LCLR;  end
                  default:      err_fire = 1'b1;
               endcase
            end
            default: begin
               unique case (cls)
                  CL_RD_ARRAY: begin
                     if (!hold) begin
                        mode_we  = 1'b1;
                        mode_nxt = RM_ARRAY;
                     end
                  end
                  CL_RD_STATUS: mode_we = 1'b1;
                  CL_RD_IDENT: begin
                     if (!(hold && HOLD_IDENT)) begin
                        mode_we  = 1'b1;
                        mode_nxt = RM_IDENT;
                     end
                  end
                  CL_CLR_SR:      clr_fire = !busy;
                  CL_ERASE_SETUP: begin pend_d = PD_ERASE; mode_we = 1'b1; end
                  CL_PROG_SETUP:  begin pend_d = PD_PROG;  mode_we = 1'b1; end
                  CL_LOCK_SETUP:  begin pend_d = PD_LOCK;  mode_we = 1'b1; end
                  CL_SUSPEND: begin
                     if (hold) begin
                        susp_fire = 1'b1;
                        mode_we   = 1'b1;
                     end
                  end
                  CL_CONFIRM: begin
                     if (suspended) begin
                        res_fire = 1'b1;
                        mode_we  = 1'b1;
                     end
                  end
                  default: ;
               endcase
            end
         endcase
      end
   end

endmodule

// File: rtl/flash_cmd_outreg.sv
module flash_cmd_outreg
   import flash_cmd_pkg::*;
#(
   parameter int AW = 20,
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] addr_in,
   input  logic [DW-1:0] data_in,
   input  logic          mode_we,
   input  rmode_e        mode_nxt,
   input  logic          op_fire,
   input  op_kind_e      kind_nxt,
   input  logic          err_fire,
   input  logic          clr_fire,
   input  logic          susp_fire,
   input  logic          res_fire,
   output rmode_e        read_mode,
   output logic          op_start,
   output op_kind_e      op_kind,
   output logic [AW-1:0] op_addr,
   output logic [DW-1:0] op_data,
   output logic          seq_error,
   output logic          clear_flags,
   output logic          suspend_req,
   output logic          resume_req
);

   localparam int NPULSE = 5;

   logic [NPULSE-1:0] pulse_d, pulse_q;

   assign pulse_d = {op_fire, err_fire, clr_fire, susp_fire, res_fire};

   genvar gi;
   generate
      for (gi = 0; gi < NPULSE; gi++) begin : g_pulse
         always_ff @(posedge clk) begin
            if (!rst_n) pulse_q[gi] <= 1'b0;
            else        pulse_q[gi] <= pulse_d[gi];
         end
      end
   endgenerate

   assign {op_start, seq_error, clear_flags, suspend_req, resume_req} = pulse_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         read_mode <= RM_ARRAY;
         op_kind   <= OK_NONE;
         op_addr   <= '0;
         op_data   <= '0;
      end else begin
         if (mode_we) read_mode <= mode_nxt;
         if (op_fire) begin
            op_kind <= kind_nxt;
            op_addr <= addr_in;
            op_data <= data_in;
         end
      end
   end

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
   import flash_cmd_pkg::*;
#(
   parameter int AW          = 20,
   parameter int DW          = 16,
   parameter bit ALT_PROG_EN = 1'b1,
   parameter bit HOLD_IDENT  = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [DW-1:0] wr_data,
   input  logic          seq_busy,
   input  logic          seq_suspended,
   output logic [1:0]    read_mode,
   output logic          op_start,
   output logic [2:0]    op_kind,
   output logic [AW-1:0] op_addr,
   output logic [DW-1:0] op_data,
   output logic          seq_error,
   output logic          clear_flags,
   output logic          suspend_req,
   output logic          resume_req
);

   initial begin
      if (DW < CMD_W) $error("flash_cmd_decoder: DW must hold a command byte");
      if (AW < 1)     $error("flash_cmd_decoder: AW must be positive");
   end

   cmd_class_e cls;
   logic       mode_we, op_fire, err_fire, clr_fire, susp_fire, res_fire;
   rmode_e     mode_nxt, mode_q;
   op_kind_e   kind_nxt, kind_q;

   flash_cmd_classify #(.CODE_W(CMD_W), .ALT_PROG_EN(ALT_PROG_EN)) u_cls (
      .code (wr_data[CMD_W-1:0]),
      .cls  (cls)
   );

   flash_cmd_seq #(.HOLD_IDENT(HOLD_IDENT)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .strobe    (wr_en),
      .cls       (cls),
      .busy      (seq_busy),
      .suspended (seq_suspended),
      .mode_we   (mode_we),
      .mode_nxt  (mode_nxt),
      .op_fire   (op_fire),
      .kind_nxt  (kind_nxt),
      .err_fire  (err_fire),
      .clr_fire  (clr_fire),
      .susp_fire (susp_fire),
      .res_fire  (res_fire)
   );

   flash_cmd_outreg #(.AW(AW), .DW(DW)) u_out (
      .clk         (clk),
      .rst_n       (rst_n),
      .addr_in     (wr_addr),
      .data_in     (wr_data),
      .mode_we     (mode_we),
      .mode_nxt    (mode_nxt),
      .op_fire     (op_fire),
      .kind_nxt    (kind_nxt),
      .err_fire    (err_fire),
      .clr_fire    (clr_fire),
      .susp_fire   (susp_fire),
      .res_fire    (res_fire),
      .read_mode   (mode_q),
      .op_start    (op_start),
      .op_kind     (kind_q),
      .op_addr     (op_addr),
      .op_data     (op_data),
      .seq_error   (seq_error),
      .clear_flags (clear_flags),
      .suspend_req (suspend_req),
      .resume_req  (resume_req)
   );

   assign read_mode = mode_q;
   assign op_kind   = kind_q;

endmodule

// File: rtl/flash_cmd_decoder_chk.sv
module flash_cmd_decoder_chk #(
   parameter int AW = 20,
   parameter int DW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          wr_en,
   input logic [AW-1:0] wr_addr,
   input logic [DW-1:0] wr_data,
   input logic          seq_busy,
   input logic          seq_suspended,
   input logic [1:0]    read_mode,
   input logic          op_start,
   input logic [2:0]    op_kind,
   input logic [AW-1:0] op_addr,
   input logic [DW-1:0] op_data,
   input logic          seq_error,
   input logic          clear_flags,
   input logic          suspend_req,
   input logic          resume_req
);

   // R1: array read mode in the first cycle out of reset
   a_r1_reset_array: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (read_mode == 2'd0));

   // R10: a started operation always leaves reads on the status register
   a_r10_start_status: assert property (@(posedge clk) disable iff (!rst_n)
      op_start |-> (read_mode == 2'd1));

   // R5: an invalid sequence never also starts an operation
   a_r5_err_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(op_start && seq_error));

   // R11: no pulse appears without a write in the previous cycle
   a_r11_no_write_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(wr_en) |-> !(op_start || seq_error || clear_flags || suspend_req || resume_req));

   // R9: status mode is kept while the sequencer runs unsuspended
   a_r9_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && seq_busy && !seq_suspended && read_mode == 2'd1) |=> (read_mode == 2'd1));

   // R3: no clear request while the sequencer is busy
   a_r3_no_clear_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && seq_busy) |=> !clear_flags);

   // R8: suspend and resume requests are mutually exclusive
   a_r8_susp_res_excl: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({suspend_req, resume_req, op_start}));

endmodule

bind flash_cmd_decoder flash_cmd_decoder_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/flash_cmd_decoder_test.sv
module flash_cmd_decoder_test;

   localparam int AW = 20;
   localparam int DW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic          seq_busy = 1'b0;
   logic          seq_suspended = 1'b0;
   logic [1:0]    read_mode;
   logic          op_start;
   logic [2:0]    op_kind;
   logic [AW-1:0] op_addr;
   logic [DW-1:0] op_data;
   logic          seq_error;
   logic          clear_flags;
   logic          suspend_req;
   logic          resume_req;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   flash_cmd_decoder #(.AW(AW), .DW(DW)) uut (.*);

   task automatic check(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
      end
   endtask

   // one bus write; returns at the falling edge after the capturing rising edge
   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic no_pulses(input string req);
      check(req, "pulses", {27'd0, op_start, seq_error, clear_flags, suspend_req, resume_req}, 32'd0);
   endtask

   task automatic t_reset;
      check("R1", "read_mode", read_mode, 0);
      no_pulses("R1");
      wr(20'h00100, 16'h00D0);
      check("R1", "no pending start", op_start, 0);
      check("R1", "mode after lone D0", read_mode, 0);
   endtask

   task automatic t_modes;
      wr(0, 16'h0070); check("R2", "status mode", read_mode, 1);
      wr(0, 16'h0090); check("R2", "ident mode", read_mode, 2);
      wr(0, 16'h00FF); check("R2", "array mode", read_mode, 0);
      wr(0, 16'hAB70); check("R12", "upper byte ignored", read_mode, 1);
      wr(0, 16'h00FF);
   endtask

   task automatic t_reserved;
      wr(0, 16'h0033);
      check("R11", "reserved mode", read_mode, 0);
      no_pulses("R11");
      wr(0, 16'h00B0);
      check("R11", "idle suspend mode", read_mode, 0);
      no_pulses("R11");
   endtask

   task automatic t_erase;
      wr(20'h12340, 16'h0020);
      check("R10", "setup gives status", read_mode, 1);
      check("R4", "no start on setup", op_start, 0);
      wr(20'h12344, 16'h00D0);
      check("R4", "erase start", op_start, 1);
      check("R4", "erase kind", op_kind, 1);
      check("R4", "erase addr", op_addr, 32'h12344);
      check("R10", "status after erase", read_mode, 1);
      @(negedge clk);
      check("R4", "start is one cycle", op_start, 0);
      wr(0, 16'h00FF);
      wr(20'h00200, 16'h0020);
      wr(20'h00200, 16'h00FF);
      check("R5", "bad confirm error", seq_error, 1);
      check("R5", "bad confirm no start", op_start, 0);
      check("R5", "bad confirm status", read_mode, 1);
      @(negedge clk);
      check("R5", "error is one cycle", seq_error, 0);
      wr(20'h00200, 16'h00D0);
      check("R5", "setup was cleared", op_start, 0);
   endtask

   task automatic t_prog;
      wr(0, 16'h0040);
      wr(20'h0ABCD, 16'hFFFF);
      check("R6", "prog start 40h", op_start, 1);
      check("R6", "prog kind", op_kind, 2);
      check("R6", "prog addr", op_addr, 32'h0ABCD);
      check("R6", "prog data", op_data, 32'hFFFF);
      wr(0, 16'h0010);
      wr(20'h00007, 16'h1234);
      check("R6", "prog start 10h", op_start, 1);
      check("R6", "prog data alt", op_data, 32'h1234);
   endtask

   task automatic t_lock;
      wr(0, 16'h0060); wr(20'h08000, 16'h0001);
      check("R7", "lock set kind", {op_start, op_kind}, 32'hB);
      wr(0, 16'h0060); wr(0, 16'h00F1);
      check("R7", "perm lock kind", {op_start, op_kind}, 32'hC);
      wr(0, 16'h0060); wr(0, 16'h00D0);
      check("R7", "lock clear kind", {op_start, op_kind}, 32'hD);
      wr(0, 16'h0060); wr(0, 16'h0077);
      check("R7", "bad lock code", {op_start, seq_error}, 32'h1);
   endtask

   task automatic t_clear;
      wr(0, 16'h0090);
      wr(0, 16'h0050);
      check("R3", "clear pulse", clear_flags, 1);
      check("R3", "mode kept", read_mode, 2);
      seq_busy = 1'b1;
      wr(0, 16'h0050);
      check("R3", "clear blocked busy", clear_flags, 0);
      seq_busy = 1'b0;
   endtask

   task automatic t_busy;
      wr(0, 16'h0070);
      seq_busy = 1'b1;
      wr(0, 16'h00FF); check("R9", "FF held busy", read_mode, 1);
      wr(0, 16'h0090); check("R9", "90 held busy", read_mode, 1);
      wr(0, 16'h00D0); check("R11", "resume when running", resume_req, 0);
      wr(0, 16'h00B0); check("R8", "suspend req", suspend_req, 1);
      seq_suspended = 1'b1;
      wr(0, 16'h00FF); check("R9", "FF while suspended", read_mode, 0);
      wr(0, 16'h00B0); check("R11", "suspend when suspended", suspend_req, 0);
      wr(0, 16'h00D0);
      check("R8", "resume req", resume_req, 1);
      check("R8", "resume gives status", read_mode, 1);
      seq_suspended = 1'b0;
      seq_busy = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_modes();
      t_reserved();
      t_erase();
      t_prog();
      t_lock();
      t_clear();
      t_busy();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule